// File: doc/BRIEF.md
# Storage I/O statistics accumulator

This block keeps the health statistics of one storage namespace. On every completed command it receives a strobe, an opcode and a zero-based block count. It keeps four 128-bit counters, each held as a low and a high half: read commands, write commands, read data units and write data units. A data unit is one thousand blocks. Blocks that do not yet make up a whole unit stay in a per-direction remainder register, so no fraction is lost from one command to the next.

On writes the block also receives the namespace's used-block count from an external utilisation tracker, as it was before the write and as it is after it, together with the namespace size. The used figure must change for the block to check spare capacity. If the spare percentage has fallen below the configured limit, the block raises a spare-capacity warning event. The event is raised only once until the next reset. It carries a type code and an info code and stays valid until the event consumer accepts it.

Top module: `iostat_accum`

## Requirements
- R1: Opcode 8'h01 is a write and 8'h02 is a read. A write changes only the write statistics and the spare check. A read changes only the read statistics. Any other opcode, or a cycle with `cmd_valid` low, leaves every output unchanged.
- R2: Each command counter is the concatenation {hi, lo} of two CNT_W-bit halves. It rises by one per accepted command. The high half increments when the low half wraps to zero.
- R3: Each command adds `cmd_nlb` + 1 blocks to its direction's remainder. The whole thousands of that sum are added to the low data-unit half, and the remainder keeps the sum modulo 1000. So {hi, lo} always equals floor(total blocks / 1000).
- R4: When an addition makes the low data-unit half numerically smaller than it was, the high half increments by one.
- R5: A write whose `used_after` equals `used_before` never raises the warning, whatever the fill level.
- R6: A write with a changed used count raises the warning when `ns_size` is nonzero and 100 − floor(`used_after`·100 / `ns_size`) < SPARE_PCT (default 10). A size of zero never raises it.
- R7: The warning is raised at most once between resets. Later qualifying writes raise no event.
- R8: The event becomes valid in the cycle after the qualifying write with `evt_type` = 3'd1 and `evt_info` = 8'h01. It holds those values until a clock edge where `evt_ready` is high.
- R9: Reset (`rst_n` low, asynchronous) clears every counter, both remainders, the issued flag and `evt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command-completion strobe |
| cmd_op | input | 8 | Opcode (8'h01 write, 8'h02 read) |
| cmd_nlb | input | BLK_W | Zero-based block count |
| used_before | input | USE_W | Used blocks before the write |
| used_after | input | USE_W | Used blocks after the write |
| ns_size | input | USE_W | Namespace size in blocks |
| evt_ready | input | 1 | Event consumer accepts |
| evt_valid | output | 1 | Spare-capacity event pending |
| evt_type | output | 3 | Event type code |
| evt_info | output | 8 | Event info code |
| rd_cmd_lo | output | CNT_W | Read command count, low half |
| rd_cmd_hi | output | CNT_W | Read command count, high half |
| wr_cmd_lo | output | CNT_W | Write command count, low half |
| wr_cmd_hi | output | CNT_W | Write command count, high half |
| rd_du_lo | output | CNT_W | Read data units, low half |
| rd_du_hi | output | CNT_W | Read data units, high half |
| wr_du_lo | output | CNT_W | Write data units, low half |
| wr_du_hi | output | CNT_W | Write data units, high half |

## Verification
A remainder that is kept badly has no visible effect at first. It shows up as a data-unit count that drifts away from floor(total/1000), and only on the command that crosses a thousand boundary. The bench therefore compares the full {hi, lo} values after every command, using large block counts so that boundaries are crossed often. A missing carry shows only when the low half wraps, so the bench builds the design with narrow halves and drives it past those wraps. Warning-latch faults show up in the cycle after the write: an event that is missing, repeated or dropped early.

// File: rtl/iostat_pkg.sv
package iostat_pkg;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;

  typedef enum logic [2:0] {
    EVT_NONE  = 3'd0,
    EVT_SMART = 3'd1
  } evt_type_e;

  localparam logic [7:0] INFO_SPARE_LOW = 8'h01;

  localparam int DIR_WR = 0;
  localparam int DIR_RD = 1;
endpackage

// File: rtl/iostat_cmd_cnt.sv
module iostat_cmd_cnt #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;

  always_comb begin
    lo_d = lo_q + W'(1);
    hi_d = hi_q;
    if (lo_d == '0) hi_d = hi_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (inc) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && lo_q == {W{1'b1}}) |=> (lo_q == '0 && hi_q == $past(hi_q) + W'(1)));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/iostat_unit_acc.sv
module iostat_unit_acc #(
  parameter int W     = 64,
  parameter int BLK_W = 16,
  parameter int DIV   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BLK_W-1:0] nlb,
  output logic [W-1:0]     lo,
  output logic [W-1:0]     hi
);
  localparam int RES_W = $clog2(DIV);
  localparam int SUM_W = ((RES_W > BLK_W) ? RES_W : BLK_W) + 2;

  logic [RES_W-1:0] res_q, res_d;
  logic [W-1:0]     lo_q, hi_q, lo_d, hi_d;
  logic [SUM_W-1:0] sum, quot;

  always_comb begin
    sum   = SUM_W'(res_q) + SUM_W'(nlb) + SUM_W'(1);
    quot  = sum / SUM_W'(DIV);
    res_d = RES_W'(sum % SUM_W'(DIV));
    lo_d  = lo_q + W'(quot);
    hi_d  = hi_q;
    if (lo_d < lo_q) hi_d = hi_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (en) begin
      res_q <= res_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

  assign lo = lo_q;
  assign hi = hi_q;

  assert_residue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_q < RES_W'(DIV));
  assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q != $past(hi_q)) |-> (hi_q == $past(hi_q) + W'(1) && lo_q < $past(lo_q)));
endmodule

// File: rtl/iostat_spare_mon.sv
module iostat_spare_mon
  import iostat_pkg::*;
#(
  parameter int USE_W     = 64,
  parameter int SPARE_PCT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [USE_W-1:0] used_before,
  input  logic [USE_W-1:0] used_after,
  input  logic [USE_W-1:0] ns_size,
  input  logic             evt_ready,
  output logic             evt_valid,
  output logic [2:0]       evt_type,
  output logic [7:0]       evt_info
);
  localparam int P_W = USE_W + 7;
  localparam logic [P_W-1:0] LIMIT = P_W'(100 - SPARE_PCT);

  logic             issued_q, issued_d, vld_q, vld_d;
  logic [P_W-1:0]   prod, pct;
  logic             low_spare, fire;

  always_comb begin
    prod      = P_W'(used_after) * P_W'(100);
    pct       = (ns_size == '0) ? '0 : prod / P_W'(ns_size);
    low_spare = (ns_size != '0) && (pct > LIMIT);
    fire      = chk_en && (used_after != used_before) && !issued_q && low_spare;
    issued_d  = issued_q;
    vld_d     = vld_q;
    if (vld_q && evt_ready) vld_d = 1'b0;
    if (fire) begin
      issued_d = 1'b1;
      vld_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issued_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      issued_q <= issued_d;
      vld_q    <= vld_d;
    end
  end

  assign evt_valid = vld_q;
  assign evt_type  = vld_q ? EVT_SMART : EVT_NONE;
  assign evt_info  = vld_q ? INFO_SPARE_LOW : 8'h00;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !evt_ready) |=> vld_q);
  assert_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> !$past(issued_q));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q |=> issued_q);
  assert_zero_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && ns_size == '0) |=> !$rose(vld_q));
endmodule

// File: rtl/iostat_accum.sv
module iostat_accum
  import iostat_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int BLK_W     = 16,
  parameter int USE_W     = 64,
  parameter int UNIT_DIV  = 1000,
  parameter int SPARE_PCT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_nlb,
  input  logic [USE_W-1:0] used_before,
  input  logic [USE_W-1:0] used_after,
  input  logic [USE_W-1:0] ns_size,
  input  logic             evt_ready,
  output logic             evt_valid,
  output logic [2:0]       evt_type,
  output logic [7:0]       evt_info,
  output logic [CNT_W-1:0] rd_cmd_lo,
  output logic [CNT_W-1:0] rd_cmd_hi,
  output logic [CNT_W-1:0] wr_cmd_lo,
  output logic [CNT_W-1:0] wr_cmd_hi,
  output logic [CNT_W-1:0] rd_du_lo,
  output logic [CNT_W-1:0] rd_du_hi,
  output logic [CNT_W-1:0] wr_du_lo,
  output logic [CNT_W-1:0] wr_du_hi
);
  localparam int N_DIR = 2;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_DIR-1:0]            dir_en;
  logic [N_DIR-1:0][CNT_W-1:0] c_lo, c_hi, u_lo, u_hi;

  assign dir_en[DIR_WR] = cmd_valid && (cmd_op == OP_WRITE);
  assign dir_en[DIR_RD] = cmd_valid && (cmd_op == OP_READ);

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    iostat_cmd_cnt #(.W(CNT_W)) u_cmd (
      .clk  (clk),
      .rst_n(rst_sync_q),
      .inc  (dir_en[d]),
      .lo   (c_lo[d]),
      .hi   (c_hi[d])
    );
    iostat_unit_acc #(.W(CNT_W), .BLK_W(BLK_W), .DIV(UNIT_DIV)) u_du (
      .clk  (clk),
      .rst_n(rst_sync_q),
      .en   (dir_en[d]),
      .nlb  (cmd_nlb),
      .lo   (u_lo[d]),
      .hi   (u_hi[d])
    );
  end

  iostat_spare_mon #(.USE_W(USE_W), .SPARE_PCT(SPARE_PCT)) u_spare (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .chk_en     (dir_en[DIR_WR]),
    .used_before(used_before),
    .used_after (used_after),
    .ns_size    (ns_size),
    .evt_ready  (evt_ready),
    .evt_valid  (evt_valid),
    .evt_type   (evt_type),
    .evt_info   (evt_info)
  );

  assign wr_cmd_lo = c_lo[DIR_WR];
  assign wr_cmd_hi = c_hi[DIR_WR];
  assign rd_cmd_lo = c_lo[DIR_RD];
  assign rd_cmd_hi = c_hi[DIR_RD];
  assign wr_du_lo  = u_lo[DIR_WR];
  assign wr_du_hi  = u_hi[DIR_WR];
  assign rd_du_lo  = u_lo[DIR_RD];
  assign rd_du_hi  = u_hi[DIR_RD];

  assert_other_op_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (dir_en == '0) |=> ($stable(c_lo) && $stable(c_hi) && $stable(u_lo) && $stable(u_hi)));
  assert_rd_no_wr_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    dir_en[DIR_RD] |=> ($stable(c_lo[DIR_WR]) && $stable(u_lo[DIR_WR])));
endmodule

// File: tb/iostat_accum_tb.sv
module iostat_accum_tb;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [15:0] cmd_nlb = '0;
  logic [15:0] used_before = '0, used_after = '0, ns_size = '0;
  logic        evt_ready = 1'b1;
  logic        evt_valid;
  logic [2:0]  evt_type;
  logic [7:0]  evt_info;
  logic [CW-1:0] rd_cmd_lo, rd_cmd_hi, wr_cmd_lo, wr_cmd_hi;
  logic [CW-1:0] rd_du_lo, rd_du_hi, wr_du_lo, wr_du_hi;

  always #2 clk = ~clk;

  iostat_accum #(.CNT_W(CW), .BLK_W(16), .USE_W(16), .UNIT_DIV(1000), .SPARE_PCT(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_nlb(cmd_nlb),
    .used_before(used_before), .used_after(used_after), .ns_size(ns_size),
    .evt_ready(evt_ready), .evt_valid(evt_valid), .evt_type(evt_type), .evt_info(evt_info),
    .rd_cmd_lo(rd_cmd_lo), .rd_cmd_hi(rd_cmd_hi), .wr_cmd_lo(wr_cmd_lo), .wr_cmd_hi(wr_cmd_hi),
    .rd_du_lo(rd_du_lo), .rd_du_hi(rd_du_hi), .wr_du_lo(wr_du_lo), .wr_du_hi(wr_du_hi)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  longint m_rd_cmd = 0, m_wr_cmd = 0, m_rd_blk = 0, m_wr_blk = 0;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] nlb;
    logic [15:0] ub;
    logic [15:0] ua;
    logic [15:0] sz;
    logic        ev;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h02, 16'd0,     16'd0,   16'd0,   16'd1000, 1'b0},  // read
    '{8'h01, 16'd999,   16'd0,   16'd100, 16'd1000, 1'b0},  // write, low fill
    '{8'h01, 16'd499,   16'd100, 16'd900, 16'd1000, 1'b0},  // spare exactly 10
    '{8'h09, 16'd5,     16'd900, 16'd990, 16'd1000, 1'b0},  // other opcode
    '{8'h02, 16'd1999,  16'd0,   16'd0,   16'd1000, 1'b0},  // read
    '{8'h01, 16'd10,    16'd950, 16'd950, 16'd1000, 1'b0},  // unchanged use
    '{8'h01, 16'd3,     16'd1,   16'd2,   16'd0,    1'b0},  // size zero
    '{8'h01, 16'd0,     16'd900, 16'd910, 16'd1000, 1'b1},  // warning
    '{8'h01, 16'd600,   16'd910, 16'd990, 16'd1000, 1'b0},  // already issued
    '{8'h02, 16'd65535, 16'd0,   16'd0,   16'd1000, 1'b0}   // large read
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] op, input logic [15:0] nlb,
                        input logic [15:0] ub, input logic [15:0] ua, input logic [15:0] sz);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_nlb = nlb;
    used_before = ub; used_after = ua; ns_size = sz;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 8'h01) begin m_wr_cmd++; m_wr_blk += longint'(nlb) + 1; end
    if (op == 8'h02) begin m_rd_cmd++; m_rd_blk += longint'(nlb) + 1; end
  endtask

  task automatic cmp_all(input string tag);
    longint e;
    e = m_rd_cmd % 65536;
    chk({rd_cmd_hi, rd_cmd_lo} == 16'(e), {tag, " R2 rd_cmd"}, longint'({rd_cmd_hi, rd_cmd_lo}), e);
    e = m_wr_cmd % 65536;
    chk({wr_cmd_hi, wr_cmd_lo} == 16'(e), {tag, " R2 wr_cmd"}, longint'({wr_cmd_hi, wr_cmd_lo}), e);
    e = (m_rd_blk / 1000) % 65536;
    chk({rd_du_hi, rd_du_lo} == 16'(e), {tag, " R3 rd_du"}, longint'({rd_du_hi, rd_du_lo}), e);
    e = (m_wr_blk / 1000) % 65536;
    chk({wr_du_hi, wr_du_lo} == 16'(e), {tag, " R3 wr_du"}, longint'({wr_du_hi, wr_du_lo}), e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_rd_cmd = 0; m_wr_cmd = 0; m_rd_blk = 0; m_wr_blk = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R9 reset state
    chk(evt_valid == 1'b0, "R9 evt_valid in reset", evt_valid, 0);
    chk({rd_cmd_hi, rd_cmd_lo, wr_cmd_hi, wr_cmd_lo, rd_du_hi, rd_du_lo, wr_du_hi, wr_du_lo} == '0,
        "R9 counters in reset", longint'(wr_du_lo), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table: R1 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i].op, VEC[i].nlb, VEC[i].ub, VEC[i].ua, VEC[i].sz);
      cmp_all($sformatf("R1 vec%0d", i));
      chk(evt_valid == VEC[i].ev, $sformatf("R6 vec%0d evt", i), evt_valid, VEC[i].ev);
      if (VEC[i].ev)
        chk(evt_type == 3'd1 && evt_info == 8'h01, "R8 event codes",
            longint'({evt_type, evt_info}), longint'({3'd1, 8'h01}));
    end

    // R9 reset clears nonzero counters
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({rd_cmd_hi, rd_cmd_lo, wr_cmd_hi, wr_cmd_lo, rd_du_hi, rd_du_lo, wr_du_hi, wr_du_lo} == '0,
        "R9 counters cleared", longint'(rd_cmd_lo), 0);
    rst_n = 1'b1;
    m_rd_cmd = 0; m_wr_cmd = 0; m_rd_blk = 0; m_wr_blk = 0;
    repeat (3) @(negedge clk);
    // remainder cleared: 999 blocks alone must not complete a unit
    do_cmd(8'h02, 16'd998, 16'd0, 16'd0, 16'd1000);
    chk({rd_du_hi, rd_du_lo} == '0, "R9 remainder cleared", longint'(rd_du_lo), 0);
    do_cmd(8'h02, 16'd0, 16'd0, 16'd0, 16'd1000);
    chk({rd_du_hi, rd_du_lo} == 16'd1, "R3 thousand boundary", longint'(rd_du_lo), 1);

    // R8 hold with ready low; also R7 flag cleared by reset (R9)
    evt_ready = 1'b0;
    do_cmd(8'h01, 16'd0, 16'd900, 16'd950, 16'd1000);
    chk(evt_valid == 1'b1, "R9 warning re-armed after reset", evt_valid, 1);
    repeat (3) @(negedge clk);
    chk(evt_valid == 1'b1 && evt_type == 3'd1 && evt_info == 8'h01, "R8 event held",
        longint'({evt_valid, evt_type, evt_info}), longint'({1'b1, 3'd1, 8'h01}));
    evt_ready = 1'b1;
    @(negedge clk);
    chk(evt_valid == 1'b0, "R8 event accepted", evt_valid, 0);
    do_cmd(8'h01, 16'd0, 16'd950, 16'd999, 16'd1000);
    chk(evt_valid == 1'b0, "R7 no second event", evt_valid, 0);

    // R2 command counter wrap
    do_reset();
    for (int k = 0; k < 300; k++) do_cmd(8'h02, 16'd0, 16'd0, 16'd0, 16'd1000);
    chk(rd_cmd_hi == 8'd1 && rd_cmd_lo == 8'd44, "R2 low half wrap",
        longint'({rd_cmd_hi, rd_cmd_lo}), 300);
    cmp_all("R2 wrap");

    // R4 data-unit carry
    for (int k = 0; k < 5; k++) begin
      do_cmd(8'h01, 16'd65535, 16'd10, 16'd10, 16'd1000);
      cmp_all($sformatf("R4 step%0d", k));
    end
    chk(wr_du_hi == 8'd1, "R4 high half carry", longint'(wr_du_hi), 1);
    chk(evt_valid == 1'b0, "R5 unchanged use no event", evt_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule